// File: doc/BRIEF.md
# NAND Bad-Block Remap Translator

This block keeps a table that maps every logical erase block of a NAND array to a physical erase block. It sends page addresses through that table. The top part of the block range is held back as a pool of spare blocks. When a user block is defective, its logical index points at a good block taken from that pool. The map is not kept in any central structure. Each spare block carries a small record in the spare area of its first page. The record holds a fixed 32-bit tag, 0x3e10c8ed, and the index of the user block it replaces.

After reset the block runs a discovery sequence over a narrow spare-area port. Each read request names a block and returns one record: the tag, the 16-bit mapped index, and a flag that is set when the first spare byte of the block's first page is zero, which is the factory bad mark. Write requests store a record carrying the fixed tag and need no response. The sequence works in one of two ways:

- If the first spare block already holds a valid record, the device is formatted and the sequence rebuilds the map from the spare pool.
- Otherwise it scans every user block for the bad mark and hands out replacements.

Translation is refused while this runs. Afterwards it is purely combinational, through the registered map.

Both streams use valid/ready with the usual rules:

- A request on the spare port keeps its valid and payload steady until ready is seen high on a clock edge.
- A read's response comes back as a one-cycle pulse on `rsp_valid`, which the block always accepts.
- On the translate path, `xl_in_ready` follows `xl_out_ready` once initialisation is done, and `xl_out_valid` is `xl_in_valid` gated the same way.

Top module: `nbr_remap_xlator`

## Requirements
- R1: While reset is applied and after it, `busy` is 1 and `pool_empty` is 0. The first request after reset is a read (`req_wr`=0) of the first spare block, index NUM_BLOCKS-NUM_SPARE. Once `busy` falls it stays low, and no further spare-port requests are made.
- R2: The physical page is {map[page >> PG_OFF_W], page[PG_OFF_W-1:0]}. Pages per block are 2^PG_OFF_W. When `busy` is 0, `xl_in_ready` equals `xl_out_ready`, and `xl_out_valid` equals `xl_in_valid & xl_out_ready`.
- R3: Every block that no record or allocation has touched translates to itself. This includes blocks in the spare pool.
- R4: If the record read from the first spare block carries tag 0x3e10c8ed, every spare block is read in ascending order. Each valid record whose mapped index is below the first spare index and differs from the block's own index sets map[mapped] to that block.
- R5: During the rebuild, a record with a wrong tag or a self-referencing index changes no map entry.
- R6: On an unformatted device, each user block is read in ascending order. One whose bad flag is set gets the next good spare block. A write request then stores a record in that spare block with the mapped index equal to the bad block.
- R7: The allocation pointer starts at the first spare block. It skips spare blocks whose bad flag is set, and moves one past each block it hands out.
- R8: When the pointer passes the last block, the bad user block maps to block 0 and no record is written. `pool_empty` then rises and stays high until reset.
- R9: If the unformatted scan finds no bad user block, exactly one write is issued. It targets the first spare block and carries that block's own index.
- R10: A pending spare-port request holds its valid, direction, block and index until accepted. Every write targets a spare-pool block.
- R11: While `busy` is 1, `xl_in_ready` and `xl_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | output | 1 | Spare-port request valid |
| req_ready | input | 1 | Spare-port request accepted |
| req_wr | output | 1 | 1 = write record, 0 = read record |
| req_blk | output | BLK_W | Block whose first-page spare area is addressed |
| req_idx | output | 16 | Mapped index stored by a write |
| rsp_valid | input | 1 | One-cycle pulse carrying a read result |
| rsp_tag | input | 32 | Record tag read back |
| rsp_idx | input | 16 | Record mapped index read back |
| rsp_bad | input | 1 | First spare byte of the first page is zero |
| xl_in_valid | input | 1 | Logical page valid |
| xl_in_ready | output | 1 | Logical page accepted |
| xl_in_page | input | PAGE_W | Logical page number |
| xl_out_valid | output | 1 | Physical page valid |
| xl_out_ready | input | 1 | Downstream accepts physical page |
| xl_out_page | output | PAGE_W | Physical page number |
| busy | output | 1 | Discovery sequence running |
| pool_empty | output | 1 | Sticky: spare pool ran out |

## Verification
The assertions check these on every cycle:

- the stall during initialisation;
- preservation of the in-block page offset;
- stability of a pending spare-port request;
- the rule that writes only touch the spare pool;
- the stickiness of `busy` falling and of `pool_empty`;
- the silence of the spare port once initialisation is done.

The bench scenarios cover everything that depends on the content of the remap:

- which spare block each bad block receives;
- skipping of bad spare blocks;
- the self-mapped mark on a clean device;
- the rebuild that ignores wrong tags and self-references;
- the block-0 fallback when the pool is exhausted.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam logic [31:0] REC_TAG = 32'h3e10c8ed;

  typedef enum logic [3:0] {
    ST_PROBE, ST_PROBE_W, ST_REB, ST_REB_W, ST_SCAN, ST_SCAN_W,
    ST_ALLOC, ST_ALLOC_W, ST_WRITE, ST_MARK, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/nbr_map_table.sv
module nbr_map_table #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic [BLK_W-1:0] wdata,
  input  logic [BLK_W-1:0] raddr,
  output logic [BLK_W-1:0] rdata
);
  logic [BLK_W-1:0] ent [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_ent
    logic [BLK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= BLK_W'(g);
      else if (we && waddr == BLK_W'(g))           q <= wdata;
    end
    assign ent[g] = q;
  end

  assign rdata = ent[raddr];
endmodule

// File: rtl/nbr_xlate.sv
module nbr_xlate #(
  parameter int BLK_W    = 4,
  parameter int PG_OFF_W = 3,
  localparam int PAGE_W  = BLK_W + PG_OFF_W
) (
  input  logic              ready_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PAGE_W-1:0] in_page,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAGE_W-1:0] out_page,
  output logic [BLK_W-1:0]  map_raddr,
  input  logic [BLK_W-1:0]  map_rdata
);
  assign map_raddr = in_page[PAGE_W-1:PG_OFF_W];
  assign out_page  = {map_rdata, in_page[PG_OFF_W-1:0]};
  assign in_ready  = ready_en & out_ready;
  assign out_valid = ready_en & in_valid & out_ready;
endmodule

// File: rtl/nbr_init_seq.sv
module nbr_init_seq
  import nbr_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_SPARE  = 4,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1),
  localparam int FIRST_RES = NUM_BLOCKS - NUM_SPARE
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_wr,
  output logic [BLK_W-1:0] req_blk,
  output logic [15:0]      req_idx,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_tag,
  input  logic [15:0]      rsp_idx,
  input  logic             rsp_bad,
  output logic             map_we,
  output logic [BLK_W-1:0] map_waddr,
  output logic [BLK_W-1:0] map_wdata,
  output logic             busy,
  output logic             pool_empty
);
  seq_state_e       state;
  logic [CNT_W-1:0] cur, alloc;
  logic [BLK_W-1:0] wr_blk;
  logic             found_q;
  logic             tag_ok, last_user, last_blk, pool_out;
  seq_state_e       scan_end;

  assign tag_ok    = (rsp_tag == REC_TAG);
  assign last_user = (cur == CNT_W'(FIRST_RES - 1));
  assign last_blk  = (cur == CNT_W'(NUM_BLOCKS - 1));
  assign pool_out  = (alloc == CNT_W'(NUM_BLOCKS));
  assign scan_end  = found_q ? ST_DONE : ST_MARK;
  assign busy      = (state != ST_DONE);

  always_comb begin
    req_valid = 1'b0;
    req_wr    = 1'b0;
    req_blk   = cur[BLK_W-1:0];
    req_idx   = 16'(cur);
    unique case (state)
      ST_PROBE: begin req_valid = 1'b1; req_blk = BLK_W'(FIRST_RES); end
      ST_REB, ST_SCAN: req_valid = 1'b1;
      ST_ALLOC: begin req_valid = !pool_out; req_blk = alloc[BLK_W-1:0]; end
      ST_WRITE: begin req_valid = 1'b1; req_wr = 1'b1; req_blk = wr_blk; end
      ST_MARK: begin
        req_valid = 1'b1; req_wr = 1'b1;
        req_blk = BLK_W'(FIRST_RES); req_idx = 16'(FIRST_RES);
      end
      default: ;
    endcase
  end

  always_comb begin
    map_we    = 1'b0;
    map_waddr = cur[BLK_W-1:0];
    map_wdata = '0;
    unique case (state)
      ST_REB_W: if (rsp_valid && tag_ok && rsp_idx != 16'(cur) &&
                    rsp_idx < 16'(FIRST_RES)) begin
        map_we    = 1'b1;
        map_waddr = rsp_idx[BLK_W-1:0];
        map_wdata = cur[BLK_W-1:0];
      end
      ST_ALLOC:   map_we = pool_out;
      ST_ALLOC_W: if (rsp_valid && !rsp_bad) begin
        map_we    = 1'b1;
        map_wdata = alloc[BLK_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_PROBE;
      cur        <= '0;
      alloc      <= CNT_W'(FIRST_RES);
      wr_blk     <= '0;
      found_q    <= 1'b0;
      pool_empty <= 1'b0;
    end else begin
      unique case (state)
        ST_PROBE: if (req_ready) state <= ST_PROBE_W;
        ST_PROBE_W: if (rsp_valid) begin
          if (tag_ok) begin cur <= CNT_W'(FIRST_RES); state <= ST_REB; end
          else        begin cur <= '0;                state <= ST_SCAN; end
        end
        ST_REB: if (req_ready) state <= ST_REB_W;
        ST_REB_W: if (rsp_valid) begin
          if (map_we) alloc <= cur + 1'b1;
          if (last_blk) state <= ST_DONE;
          else begin cur <= cur + 1'b1; state <= ST_REB; end
        end
        ST_SCAN: if (req_ready) state <= ST_SCAN_W;
        ST_SCAN_W: if (rsp_valid) begin
          if (rsp_bad) begin found_q <= 1'b1; state <= ST_ALLOC; end
          else if (last_user) state <= scan_end;
          else begin cur <= cur + 1'b1; state <= ST_SCAN; end
        end
        ST_ALLOC: begin
          if (pool_out) begin
            pool_empty <= 1'b1;
            if (last_user) state <= ST_DONE;
            else begin cur <= cur + 1'b1; state <= ST_SCAN; end
          end else if (req_ready) state <= ST_ALLOC_W;
        end
        ST_ALLOC_W: if (rsp_valid) begin
          alloc <= alloc + 1'b1;
          if (rsp_bad) state <= ST_ALLOC;
          else begin wr_blk <= alloc[BLK_W-1:0]; state <= ST_WRITE; end
        end
        ST_WRITE: if (req_ready) begin
          if (last_user) state <= ST_DONE;
          else begin cur <= cur + 1'b1; state <= ST_SCAN; end
        end
        ST_MARK: if (req_ready) state <= ST_DONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nbr_remap_xlator.sv
module nbr_remap_xlator #(
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_SPARE  = 4,
  parameter int PG_OFF_W   = 3,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PAGE_W    = BLK_W + PG_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_wr,
  output logic [BLK_W-1:0]  req_blk,
  output logic [15:0]       req_idx,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_tag,
  input  logic [15:0]       rsp_idx,
  input  logic              rsp_bad,
  input  logic              xl_in_valid,
  output logic              xl_in_ready,
  input  logic [PAGE_W-1:0] xl_in_page,
  output logic              xl_out_valid,
  input  logic              xl_out_ready,
  output logic [PAGE_W-1:0] xl_out_page,
  output logic              busy,
  output logic              pool_empty
);
  logic             map_we;
  logic [BLK_W-1:0] map_waddr, map_wdata, map_raddr, map_rdata;

  nbr_init_seq #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_SPARE(NUM_SPARE)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_blk, .req_idx,
    .rsp_valid, .rsp_tag, .rsp_idx, .rsp_bad,
    .map_we, .map_waddr, .map_wdata, .busy, .pool_empty
  );

  nbr_map_table #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk, .rst_n, .we(map_we), .waddr(map_waddr), .wdata(map_wdata),
    .raddr(map_raddr), .rdata(map_rdata)
  );

  nbr_xlate #(.BLK_W(BLK_W), .PG_OFF_W(PG_OFF_W)) u_xl (
    .ready_en(!busy), .in_valid(xl_in_valid), .in_ready(xl_in_ready),
    .in_page(xl_in_page), .out_valid(xl_out_valid), .out_ready(xl_out_ready),
    .out_page(xl_out_page), .map_raddr, .map_rdata
  );
endmodule

// File: rtl/nbr_remap_chk.sv
module nbr_remap_chk #(
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_SPARE  = 4,
  parameter int PG_OFF_W   = 3,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PAGE_W    = BLK_W + PG_OFF_W,
  localparam int FIRST_RES = NUM_BLOCKS - NUM_SPARE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [BLK_W-1:0]  req_blk,
  input logic [15:0]       req_idx,
  input logic              xl_in_ready,
  input logic [PAGE_W-1:0] xl_in_page,
  input logic              xl_out_valid,
  input logic [PAGE_W-1:0] xl_out_page,
  input logic              busy,
  input logic              pool_empty
);
  p_stall_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!xl_in_ready && !xl_out_valid));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_out_valid |-> xl_out_page[PG_OFF_W-1:0] == xl_in_page[PG_OFF_W-1:0]);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_wr) &&
                                   $stable(req_blk) && $stable(req_idx)));

  p_write_in_pool_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr) |-> req_blk >= BLK_W'(FIRST_RES));

  p_empty_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |=> pool_empty);

  p_done_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  p_quiet_after_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind nbr_remap_xlator nbr_remap_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .NUM_SPARE(NUM_SPARE), .PG_OFF_W(PG_OFF_W)
) u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_blk, .req_idx,
  .xl_in_ready, .xl_in_page, .xl_out_valid, .xl_out_page, .busy, .pool_empty
);

// File: tb/nbr_remap_xlator_tb.sv
module nbr_remap_xlator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16, NS = 4, OFFW = 3;
  localparam int BW = 4, PW = 7, FR = NB - NS;
  localparam logic [31:0] TAG = 32'h3e10c8ed;
  localparam int TV_N = 13;
  // {scenario, logical page, expected physical page}
  localparam logic [19:0] TV [TV_N] = '{
    {4'd0, 8'd19, 8'd107}, {4'd0, 8'd40, 8'd112}, {4'd0, 8'd7, 8'd7},
    {4'd0, 8'd95, 8'd95},  {4'd0, 8'd96, 8'd96},
    {4'd1, 8'd19, 8'd19},  {4'd1, 8'd40, 8'd40},
    {4'd2, 8'd59, 8'd107}, {4'd2, 8'd24, 8'd24},  {4'd2, 8'd104, 8'd104},
    {4'd3, 8'd10, 8'd114}, {4'd3, 8'd17, 8'd121}, {4'd3, 8'd29, 8'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ready = 1'b0, req_wr;
  logic [BW-1:0] req_blk;
  logic [15:0] req_idx;
  logic rsp_valid = 1'b0, rsp_bad = 1'b0;
  logic [31:0] rsp_tag = '0;
  logic [15:0] rsp_idx = '0;
  logic xl_in_valid = 1'b0, xl_in_ready, xl_out_valid, xl_out_ready = 1'b0;
  logic [PW-1:0] xl_in_page = '0, xl_out_page;
  logic busy, pool_empty;

  int n_chk = 0, n_bad = 0;
  logic [31:0] d_tag [NB];
  logic [15:0] d_idx [NB];
  logic        d_bad [NB];
  int wr_n;
  int wr_blk_log [8];
  int wr_idx_log [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_remap_xlator #(.NUM_BLOCKS(NB), .NUM_SPARE(NS), .PG_OFF_W(OFFW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_blk, .req_idx,
    .rsp_valid, .rsp_tag, .rsp_idx, .rsp_bad,
    .xl_in_valid, .xl_in_ready, .xl_in_page, .xl_out_valid, .xl_out_ready,
    .xl_out_page, .busy, .pool_empty
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Device model: answers reads one cycle after acceptance, logs writes.
  initial begin
    bit pend = 1'b0;
    int pblk = 0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        pend = 1'b0; rsp_valid = 1'b0; req_ready = 1'b0;
      end else begin
        rsp_valid = pend;
        if (pend) begin
          rsp_tag = d_tag[pblk]; rsp_idx = d_idx[pblk]; rsp_bad = d_bad[pblk];
        end
        pend = 1'b0;
        req_ready = (cyc % 3) != 0;
        if (req_valid && req_ready) begin
          if (req_wr) begin
            if (wr_n < 8) begin
              wr_blk_log[wr_n] = int'(req_blk);
              wr_idx_log[wr_n] = int'(req_idx);
            end
            wr_n++;
            d_tag[req_blk] = TAG; d_idx[req_blk] = req_idx;
          end else begin
            pend = 1'b1; pblk = int'(req_blk);
          end
        end
      end
    end
  end

  task automatic set_dev(input int sc);
    for (int b = 0; b < NB; b++) begin
      d_tag[b] = 32'hffff_ffff; d_idx[b] = 16'hffff; d_bad[b] = 1'b0;
    end
    wr_n = 0;
    case (sc)
      0: begin d_bad[2] = 1'b1; d_bad[5] = 1'b1; d_bad[12] = 1'b1; end
      2: begin
        d_tag[12] = TAG; d_idx[12] = 16'd12;
        d_tag[13] = TAG; d_idx[13] = 16'd7;
        d_tag[14] = 32'h1234_5678; d_idx[14] = 16'd3;
        d_tag[15] = TAG; d_idx[15] = 16'd15;
      end
      3: begin
        d_bad[1] = 1'b1; d_bad[2] = 1'b1; d_bad[3] = 1'b1;
        d_bad[12] = 1'b1; d_bad[13] = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic run_init(input int sc);
    int w = 0;
    set_dev(sc);
    xl_in_valid = 1'b0; xl_out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy && !pool_empty && !xl_in_ready, "R1 reset state", {busy, pool_empty}, 2);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    if (sc == 0)
      chk(req_valid && !req_wr && req_blk == BW'(FR), "R1 first request", int'(req_blk), FR);
    xl_in_valid = 1'b1; xl_in_page = 7'd19;
    #1;
    chk(!xl_out_valid && !xl_in_ready, "R11 stall while busy", xl_out_valid, 0);
    xl_in_valid = 1'b0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    chk(!busy, "R1 init completes", busy, 0);
    @(negedge clk);
    #1;
    chk(!busy && !req_valid, "R1 busy stays low, port quiet", {busy, req_valid}, 0);
  endtask

  task automatic run_table(input int sc);
    for (int i = 0; i < TV_N; i++) begin
      if (int'(TV[i][19:16]) == sc) begin
        @(negedge clk);
        xl_in_valid = 1'b1; xl_out_ready = 1'b1; xl_in_page = TV[i][14:8];
        #1;
        chk(xl_out_valid && xl_in_ready && xl_out_page == TV[i][6:0],
            "R2/R3/R4/R6 translate", int'(xl_out_page), int'(TV[i][6:0]));
      end
    end
    xl_in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Scenario 0: unformatted, bad user blocks 2 and 5, spare 12 bad (R6, R7)
    run_init(0);
    run_table(0);
    chk(wr_n == 2, "R6 write count", wr_n, 2);
    chk(wr_blk_log[0] == 13 && wr_idx_log[0] == 2, "R6 first record", wr_blk_log[0], 13);
    chk(wr_blk_log[1] == 14 && wr_idx_log[1] == 5, "R7 second record", wr_blk_log[1], 14);
    chk(!pool_empty, "R8 pool not empty", pool_empty, 0);
    @(negedge clk);
    xl_in_valid = 1'b1; xl_out_ready = 1'b0; xl_in_page = 7'd19;
    #1;
    chk(!xl_in_ready && !xl_out_valid, "R2 back-pressure", xl_in_ready, 0);
    xl_in_valid = 1'b0;

    // Scenario 1: clean device, mark written (R9)
    run_init(1);
    run_table(1);
    chk(wr_n == 1, "R9 single write", wr_n, 1);
    chk(wr_blk_log[0] == FR && wr_idx_log[0] == FR, "R9 self mark", wr_idx_log[0], FR);

    // Scenario 2: formatted device, rebuild (R4, R5)
    run_init(2);
    run_table(2);
    chk(wr_n == 0, "R4 rebuild writes nothing", wr_n, 0);
    chk(!pool_empty, "R5 no error on rebuild", pool_empty, 0);

    // Scenario 3: pool exhausted (R8)
    run_init(3);
    run_table(3);
    chk(pool_empty, "R8 pool_empty raised", pool_empty, 1);
    chk(wr_n == 2, "R8 no write for unserved block", wr_n, 2);
    repeat (5) @(negedge clk);
    chk(pool_empty, "R8 pool_empty sticky", pool_empty, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule